// File: doc/BRIEF.md
# Bit-Serial EEPROM Read Sequencer

This block fetches a run of consecutive bytes from an external serial EEPROM. The EEPROM is reached over a single data-out line, a single data-in line and a serial clock that the block drives. The device is opened by two access lines that must move in a fixed order.

A host supplies a 16-bit start address, a byte count and a one-cycle start pulse. The block then opens access, shifts out the read opcode and the two address bytes, and clocks in the requested number of bytes. Each byte is handed to the host with a one-cycle valid strobe and its position in the run. Access is always closed again afterwards.

Every level of the serial clock, and every step of the access handshake, is held for a programmable number of system cycles. This keeps the serial interface slower than the system clock.

Top module: `nvm_serial_reader`

## Requirements
- R1: Access opens in two ordered steps: `acc_hi_o` goes to 1 first, and `acc_lo_o` drops to 0 only one phase later while `acc_hi_o` is still 1. `acc_lo_o` never falls while `acc_hi_o` is 0.
- R2: Access closes in two ordered steps after every transfer: `acc_lo_o` returns to 1 first, then `acc_hi_o` drops to 0 one phase later. `acc_hi_o` never falls while `acc_lo_o` is 0. When `done_o` is high, `acc_hi_o`=0 and `acc_lo_o`=1.
- R3: The first 24 serial clock pulses carry, most significant bit first, the byte 0x03, then address bits 15:8, then address bits 7:0. `sdo_o` is set up a full phase before each rising edge of `sclk_o` and held stable while `sclk_o` is high. `sclk_o` only pulses while access is open.
- R4: After the header, each data bit is sampled from `sdi_i` at the end of the clock-high phase, most significant bit first, 8 pulses per byte. Byte k (k = 0 upwards) appears on `byte_data_o` with `byte_idx_o` = k during a single-cycle `byte_valid_o`.
- R5: Each handshake step and each serial clock level lasts exactly PHASE_CYC system cycles. A transfer of N bytes gives exactly 24 + 8N clock pulses and keeps `busy_o` high for (76 + 16N) x PHASE_CYC cycles.
- R6: `busy_o` is high from the cycle after an accepted start until access is closed. `done_o` is high for exactly one cycle, the first cycle with `busy_o` low.
- R7: A start pulse while `busy_o` is high is ignored. The address, the count and the timing of the running transfer are unchanged.
- R8: A byte count of 0 still opens access, sends the 24 header bits and closes access, but produces no `byte_valid_o`.
- R9: Out of reset: `busy_o`=0, `done_o`=0, `byte_valid_o`=0, `sclk_o`=0, `acc_hi_o`=0, `acc_lo_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 16 | First EEPROM address of the run |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_data_o | output | 8 | Received byte |
| byte_idx_o | output | CNT_W | Position of the received byte within the run |
| sclk_o | output | 1 | Serial clock to the EEPROM |
| sdo_o | output | 1 | Serial data towards the EEPROM |
| sdi_i | input | 1 | Serial data from the EEPROM |
| acc_hi_o | output | 1 | Access line raised first on open, dropped last on close |
| acc_lo_o | output | 1 | Access line dropped last on open, raised first on close |

## Verification
The case hardest to reach from the ports is a start pulse that arrives in the middle of a running transfer with a different address and count. It can only be shown to be ignored if the header bits already on the wire and the total busy length stay as they were. The bench fires such a pulse part-way through the header of a long transfer. It then compares the captured opcode and address, and the busy cycle count, against the values of the first request. A behavioural EEPROM responder decodes the header from the serial pins and answers with address-derived data. Random addresses and counts are mixed with a zero-length read and a read that wraps past address 0xFFFF.

// File: rtl/nvm_rd_pkg.sv
// Package: shared constants and the sequencer state type for the
// bit-serial EEPROM read sequencer.
package nvm_rd_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          HDR_BYTES = 3;        // opcode + two address bytes
    localparam logic [7:0]  RD_OPCODE = 8'h03;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EN_HI,     // high access line raised
        ST_EN_LO,     // low access line dropped, access open
        ST_TX_SET,    // data-out set up, clock low
        ST_TX_HI,     // clock high while sending
        ST_TX_LO,     // clock low after sending
        ST_RX_HI,     // clock high while receiving
        ST_RX_LO,     // clock low after receiving
        ST_REL_LO,    // low access line raised
        ST_REL_HI     // high access line dropped, access closed
    } rd_state_e;
endpackage

// File: rtl/nvm_phase_timer.sv
// Module: nvm_phase_timer
// Counts system cycles within one sequencer phase and pulses tick_o in
// the last cycle of each phase. Assumes en_i is low in idle, so that
// every phase starts from a zero count.
module nvm_phase_timer #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int            TW   = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(PHASE_CYC - 1);

    logic [TW-1:0] cnt;

    // Cycle counter: clears when idle and wraps at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt == LAST);
endmodule

// File: rtl/nvm_byte_shifter.sv
// Module: nvm_byte_shifter
// One byte-wide shift register shared by sending and receiving. On a
// step it shifts left by one and inserts in_bit_i at the bottom, so the
// top bit is the next bit to send. It counts the bits shifted within the
// byte. Assumes load and step are never requested in the same cycle.
module nvm_byte_shifter
    import nvm_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              step_i,
    input  logic              in_bit_i,
    output logic [BYTE_W-1:0] q_o,
    output logic              first_o,
    output logic              last_o
);
    localparam int BCW = $clog2(BYTE_W);

    logic [BCW-1:0] bit_cnt;

    // Shift register and bit counter: load restarts a byte, step moves one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o     <= '0;
            bit_cnt <= '0;
        end else if (load_i) begin
            q_o     <= load_val_i;
            bit_cnt <= '0;
        end else if (step_i) begin
            q_o     <= {q_o[BYTE_W-2:0], in_bit_i};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign first_o = (bit_cnt == '0);
    assign last_o  = (bit_cnt == BCW'(BYTE_W - 1));
endmodule

// File: rtl/nvm_serial_reader.sv
// Module: nvm_serial_reader
// Reads count_i bytes from a serial EEPROM starting at addr_i. It opens
// access with an ordered two-line handshake and sends the read opcode and
// a 16-bit address, most significant bit first. It then clocks in the
// data bytes and reports each one with a valid strobe, and always closes
// access at the end. Each handshake step and each serial clock level
// lasts PHASE_CYC system cycles. Assumes the EEPROM changes sdi_i only
// while sclk_o is low.
module nvm_serial_reader
    import nvm_rd_pkg::*;
#(
    parameter int PHASE_CYC = 2,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    output logic [CNT_W-1:0]  byte_idx_o,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    output logic              acc_hi_o,
    output logic              acc_lo_o
);
    localparam logic [1:0] HDR_LAST = 2'(HDR_BYTES - 1);

    rd_state_e         st;
    logic              tick;
    logic [15:0]       addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  rx_cnt;
    logic [1:0]        hdr;

    logic              sh_load;
    logic              sh_step;
    logic              sh_in;
    logic [BYTE_W-1:0] sh_load_val;
    logic [BYTE_W-1:0] sh_q;
    logic              sh_first;
    logic              sh_last;

    nvm_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy_o),
        .tick_o (tick)
    );

    nvm_byte_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_load_val),
        .step_i     (sh_step),
        .in_bit_i   (sh_in),
        .q_o        (sh_q),
        .first_o    (sh_first),
        .last_o     (sh_last)
    );

    assign busy_o = (st != ST_IDLE);

    // Data-out shows the top shifter bit only while header bits are being sent.
    assign sdo_o = ((st == ST_TX_SET) || (st == ST_TX_HI) || (st == ST_TX_LO)) && sh_q[BYTE_W-1];

    // Shifter control: load each header byte, step per sent or received bit.
    always_comb begin
        sh_load     = 1'b0;
        sh_step     = 1'b0;
        sh_in       = 1'b0;
        sh_load_val = '0;
        case (st)
            ST_IDLE: begin
                if (start_i) begin
                    sh_load     = 1'b1;
                    sh_load_val = RD_OPCODE;
                end
            end
            ST_TX_LO: begin
                if (tick) begin
                    if (sh_last) begin
                        sh_load = 1'b1;
                        if (hdr == 2'd0) begin
                            sh_load_val = addr_q[15:8];
                        end else if (hdr == 2'd1) begin
                            sh_load_val = addr_q[7:0];
                        end
                    end else begin
                        sh_step = 1'b1;
                    end
                end
            end
            ST_RX_HI: begin
                if (tick) begin
                    sh_step = 1'b1;
                    sh_in   = sdi_i;
                end
            end
            default: ;
        endcase
    end

    // Sequencer: access handshake, serial clock levels and byte reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            acc_hi_o     <= 1'b0;
            acc_lo_o     <= 1'b1;
            sclk_o       <= 1'b0;
            done_o       <= 1'b0;
            byte_valid_o <= 1'b0;
            byte_data_o  <= '0;
            byte_idx_o   <= '0;
            addr_q       <= '0;
            cnt_q        <= '0;
            rx_cnt       <= '0;
            hdr          <= '0;
        end else begin
            done_o       <= 1'b0;
            byte_valid_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q   <= addr_i;
                        cnt_q    <= count_i;
                        rx_cnt   <= '0;
                        hdr      <= '0;
                        acc_hi_o <= 1'b1;
                        st       <= ST_EN_HI;
                    end
                end
                ST_EN_HI: begin
                    if (tick) begin
                        acc_lo_o <= 1'b0;
                        st       <= ST_EN_LO;
                    end
                end
                ST_EN_LO: begin
                    if (tick) begin
                        st <= ST_TX_SET;
                    end
                end
                ST_TX_SET: begin
                    if (tick) begin
                        sclk_o <= 1'b1;
                        st     <= ST_TX_HI;
                    end
                end
                ST_TX_HI: begin
                    if (tick) begin
                        sclk_o <= 1'b0;
                        st     <= ST_TX_LO;
                    end
                end
                ST_TX_LO: begin
                    if (tick) begin
                        if (sh_last && hdr == HDR_LAST) begin
                            if (cnt_q == '0) begin
                                acc_lo_o <= 1'b1;
                                st       <= ST_REL_LO;
                            end else begin
                                sclk_o <= 1'b1;
                                st     <= ST_RX_HI;
                            end
                        end else begin
                            if (sh_last) begin
                                hdr <= hdr + 1'b1;
                            end
                            st <= ST_TX_SET;
                        end
                    end
                end
                ST_RX_HI: begin
                    if (tick) begin
                        sclk_o <= 1'b0;
                        if (sh_last) begin
                            byte_valid_o <= 1'b1;
                            byte_data_o  <= {sh_q[BYTE_W-2:0], sdi_i};
                            byte_idx_o   <= rx_cnt;
                            rx_cnt       <= rx_cnt + 1'b1;
                        end
                        st <= ST_RX_LO;
                    end
                end
                ST_RX_LO: begin
                    if (tick) begin
                        if (sh_first && rx_cnt == cnt_q) begin
                            acc_lo_o <= 1'b1;
                            st       <= ST_REL_LO;
                        end else begin
                            sclk_o <= 1'b1;
                            st     <= ST_RX_HI;
                        end
                    end
                end
                ST_REL_LO: begin
                    if (tick) begin
                        acc_hi_o <= 1'b0;
                        st       <= ST_REL_HI;
                    end
                end
                ST_REL_HI: begin
                    if (tick) begin
                        done_o <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_OPEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_lo_o) |-> (acc_hi_o && $past(acc_hi_o)));                    // R1
    AST_CLOSE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_hi_o) |-> (acc_lo_o && $past(acc_lo_o)));                    // R2
    AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!acc_hi_o && acc_lo_o && !busy_o));                        // R2
    AST_SCLK_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (acc_hi_o && !acc_lo_o));                                   // R3
    AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));                         // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);                                       // R4
    AST_VALID_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (busy_o && acc_hi_o && !acc_lo_o));                   // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                   // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(addr_q) && $stable(cnt_q)));          // R7
endmodule

// File: tb/nvm_serial_reader_test.sv
`timescale 1ns/1ps
module nvm_serial_reader_test;
    localparam int P  = 2;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [15:0]   addr_i = '0;
    logic [CW-1:0] count_i = '0;
    logic          busy_o, done_o, byte_valid_o, sclk_o, sdo_o, acc_hi_o, acc_lo_o;
    logic [7:0]    byte_data_o;
    logic [CW-1:0] byte_idx_o;
    logic          sdi_i = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    nvm_serial_reader #(.PHASE_CYC(P), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .count_i(count_i),
        .busy_o(busy_o), .done_o(done_o), .byte_valid_o(byte_valid_o),
        .byte_data_o(byte_data_o), .byte_idx_o(byte_idx_o), .sclk_o(sclk_o),
        .sdo_o(sdo_o), .sdi_i(sdi_i), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Monitor and responder state
    int          busy_cyc, rx_n, viol_order, viol_sclk, hi_run, bad_hi, pulses, bit_pos;
    logic [23:0] cmd;
    logic [7:0]  got_data [0:255];
    int          got_idx  [0:255];

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Responder: capture header bits on rising serial clock.
    initial forever begin
        @(posedge sclk_o);
        if (rst_n) begin
            if (!(acc_hi_o === 1'b1 && acc_lo_o === 1'b0)) viol_sclk++;
            if (bit_pos < 24) cmd = {cmd[22:0], sdo_o};
            bit_pos++;
            pulses++;
        end
    end

    // Responder: present the next data bit after each falling serial clock.
    initial forever begin
        @(negedge sclk_o);
        if (rst_n && bit_pos >= 24) begin
            int k;
            logic [7:0] b;
            k = bit_pos - 24;
            b = mem_at(cmd[15:0] + 16'(k / 8));
            sdi_i = b[7 - (k % 8)];
        end
    end

    // Access line order watchers.
    initial forever begin
        @(negedge acc_lo_o);
        if (rst_n && acc_hi_o !== 1'b1) viol_order++;
        bit_pos = 0;
    end
    initial forever begin
        @(negedge acc_hi_o);
        if (rst_n && acc_lo_o !== 1'b1) viol_order++;
    end

    // Cycle monitor: busy length, clock-high run length, received bytes.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (busy_o) busy_cyc++;
            if (sclk_o) hi_run++;
            else if (hi_run != 0) begin
                if (hi_run != P) bad_hi++;
                hi_run = 0;
            end
            if (byte_valid_o && rx_n < 256) begin
                got_data[rx_n] = byte_data_o;
                got_idx[rx_n]  = int'(byte_idx_o);
                rx_n++;
            end
        end
    end

    task automatic run_xfer(input logic [15:0] a, input int n, input bit poke);
        int t;
        string rq;
        rq = (n == 0) ? "R8" : "R4";
        @(negedge clk); #1;
        busy_cyc = 0; rx_n = 0; viol_order = 0; viol_sclk = 0; bad_hi = 0; pulses = 0; cmd = '0;
        start_i = 1'b1; addr_i = a; count_i = CW'(n);
        @(negedge clk); #1;
        start_i = 1'b0; addr_i = ~a; count_i = CW'(n + 3);
        chk(busy_o === 1'b1, "R6", "busy after start", int'(busy_o), 1);
        if (poke) begin
            repeat (37) @(negedge clk);
            #1;
            start_i = 1'b1;
            @(negedge clk); #1;
            start_i = 1'b0;
        end
        t = 0;
        while (done_o !== 1'b1 && t < 30000) begin
            @(negedge clk); #1;
            t++;
        end
        chk(done_o === 1'b1, "R6", "done seen", int'(done_o), 1);
        chk(busy_o === 1'b0, "R6", "busy low with done", int'(busy_o), 0);
        chk(acc_hi_o === 1'b0 && acc_lo_o === 1'b1, "R2", "access closed at done",
            int'({acc_hi_o, acc_lo_o}), 1);
        chk(viol_order == 0, "R1", "access order violations", viol_order, 0);
        chk(viol_sclk == 0, "R3", "clock outside open access", viol_sclk, 0);
        chk(cmd == {8'h03, a}, poke ? "R7" : "R3", "header bits", int'(cmd), int'({8'h03, a}));
        chk(pulses == 24 + 8 * n, poke ? "R7" : "R5", "clock pulses", pulses, 24 + 8 * n);
        chk(busy_cyc == (76 + 16 * n) * P, poke ? "R7" : "R5", "busy cycles", busy_cyc, (76 + 16 * n) * P);
        chk(bad_hi == 0, "R5", "clock high length errors", bad_hi, 0);
        chk(rx_n == n, rq, "bytes received", rx_n, n);
        for (int k = 0; k < n && k < rx_n; k++) begin
            chk(got_data[k] == mem_at(a + 16'(k)), "R4", "byte data", int'(got_data[k]),
                int'(mem_at(a + 16'(k))));
            chk(got_idx[k] == k, "R4", "byte index", got_idx[k], k);
        end
        @(negedge clk); #1;
        chk(done_o === 1'b0, "R6", "done one cycle", int'(done_o), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        #1;
        chk(busy_o === 1'b0 && done_o === 1'b0 && byte_valid_o === 1'b0, "R9", "reset status",
            int'({busy_o, done_o, byte_valid_o}), 0);
        chk(sclk_o === 1'b0 && acc_hi_o === 1'b0 && acc_lo_o === 1'b1, "R9", "reset serial lines",
            int'({sclk_o, acc_hi_o, acc_lo_o}), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer(16'h1234, 0, 1'b0);      // R8 zero-length read
        run_xfer(16'h0000, 1, 1'b0);      // single byte
        run_xfer(16'hFFFE, 4, 1'b0);      // address wraps in the EEPROM
        run_xfer(16'hA5C3, 40, 1'b1);     // R7 start during a long transfer
        run_xfer(16'h8001, 2, 1'b1);      // R7 start during the header
        for (int i = 0; i < 10; i++) begin
            logic [15:0] ra;
            int rn;
            ra = 16'($urandom);
            rn = int'($urandom_range(1, 24));
            run_xfer(ra, rn, 1'(i % 3 == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule